// File: doc/BRIEF.md
# Prioritized Interrupt Encoder with Vector Return

This block gathers four groups of interrupt sources: backplane interrupt lines, local device lines, error/status events and interprocessor switch events. It reduces them to one 3-bit priority code for the local processor. Each source has a programmable level from 0 to 7, and level 0 disables it. Local lines can also be set for edge or level sensing, for active-high or active-low polarity, and for whether this block or the requesting device provides the status/ID vector.

The processor runs an acknowledge cycle for the level it sees. The block answers one cycle later with the vector of the winning source. The winner is the pending source at that level with the lowest index. The acknowledge also clears the winner's edge latch. A vector is an upper base field, which software can write, joined to the 5-bit source index.

Source indices are fixed. Backplane lines take indices 0 to 6, local lines 7 to 13, error/status events 14 to 19 (power fail, system fail, posted-write bus error, block-DMA done, arbitration timeout, interrupter event) and switch events 20 to 27 (four module switches, then four global switches).

Top module: `pic_irq_ctrl`

## Requirements
- R1: After synchronous reset, `ipl_o` is 0. Every source reads back 0x30: level 0, level sensing, active-high and block-supplied vector. The vector base reads back 0x02.
- R2: Two clock edges after an input changes, `ipl_o` equals the highest level among the pending enabled sources, or 0 when none is pending.
- R3: A source at level 0 never requests and latches nothing. Setting a source to level 0 discards a request it has already latched.
- R4: A local line in level mode (config bit 3 = 0) requests only while its input is active.
- R5: A local line in edge mode (config bit 3 = 1) latches a request on an inactive-to-active transition. The request stays after the input returns inactive, until that source wins an acknowledge.
- R6: For a local line, config bit 4 = 1 means active-high and bit 4 = 0 means active-low.
- R7: A pulse on `iack_req_i` with level L gives `iack_ack_o` = 1 on the next cycle only. If a source is pending at level L, `iack_hit_o` is 1 and `iack_vec_o` is {base, 5-bit index} of the lowest-indexed such source.
- R8: An acknowledge clears only the winner's edge latch. A level-mode request still active keeps requesting.
- R9: When a local line's config bit 5 is 0, its acknowledge gives `iack_own_o` = 0 and a vector of 0. Every other group always gives `iack_own_o` = 1.
- R10: Backplane lines are always level-sensed and active-high. Error and switch events are always latched on their rising edge. Config bits 3 to 5 written for these groups have no effect on sensing or on `iack_own_o`.
- R11: An acknowledge at a level with no pending source, or at level 0, gives `iack_hit_o` = 0, `iack_own_o` = 0 and a vector of 0.
- R12: A write to `cfg_addr_i` 0..27 sets source config bits [5:0] = {vector supply, polarity, edge mode, level[2:0]}. A write to address 28 sets the 3-bit vector base. A read pulse returns the addressed value on `cfg_rdata_o` one cycle later, and `cfg_rdata_o` holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_irq_i | input | 7 | Backplane interrupt lines, active-high |
| loc_irq_i | input | 7 | Local device interrupt lines |
| err_evt_i | input | 6 | Error/status events |
| sw_evt_i | input | 8 | Module switch (3:0) and global switch (7:4) events |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_re_i | input | 1 | Config read strobe |
| cfg_addr_i | input | 5 | Source index 0..27, or 28 for the vector base |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Registered read data |
| ipl_o | output | 3 | Encoded priority, 0 = no request |
| iack_req_i | input | 1 | Acknowledge request pulse |
| iack_lvl_i | input | 3 | Level being acknowledged |
| iack_ack_o | output | 1 | Acknowledge response strobe |
| iack_hit_o | output | 1 | A source matched the acknowledged level |
| iack_own_o | output | 1 | This block supplies the vector |
| iack_vec_o | output | 8 | Status/ID vector |

## Verification
The bench sets two local lines at the same level and checks that the lower index wins. A tie-break that picked the higher index would return the wrong vector. It pulses edge-mode sources for a single cycle and checks that the request stays until acknowledged and then goes. A design that used level sensing there, or that failed to clear on acknowledge, would drop the pulse or leave the priority stuck. It also writes mode and supply bits to the fixed-sense groups, flips polarity on a local line, and disables a source that holds a latched request. A design that honoured those bits, ignored polarity, or kept the stale latch would show the wrong priority code or the wrong owner flag.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVLW = 3;

  typedef struct packed {
    logic            vsup;     // block supplies the vector
    logic            act_hi;   // 1 = active-high input
    logic            edge_md;  // 1 = edge latched
    logic [LVLW-1:0] lvl;      // 0 = disabled
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{vsup: 1'b1, act_hi: 1'b1, edge_md: 1'b0, lvl: '0};
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NSRC      = 28,
  parameter int AW        = 5,
  parameter int VBW       = 3,
  parameter int VBASE_RST = 2,
  parameter int DW        = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output src_cfg_t [NSRC-1:0]   cfg_o,
  output logic [VBW-1:0]        vbase_o,
  output logic [DW-1:0]         rdata_o
);
  localparam int CW = $bits(src_cfg_t);

  src_cfg_t [NSRC-1:0] cfg_q;
  logic [VBW-1:0]      vbase_q;
  logic [DW-1:0]       rd_c;

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= CFG_RST;
      else if (we_i && addr_i == AW'(g))
        cfg_q[g] <= src_cfg_t'(wdata_i[CW-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      vbase_q <= VBW'(VBASE_RST);
    else if (we_i && addr_i == AW'(NSRC))
      vbase_q <= wdata_i[VBW-1:0];
  end

  always_comb begin
    rd_c = '0;
    for (int i = 0; i < NSRC; i++)
      if (addr_i == AW'(i)) rd_c = {{(DW-CW){1'b0}}, cfg_q[i]};
    if (addr_i == AW'(NSRC)) rd_c = {{(DW-VBW){1'b0}}, vbase_q};
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= rd_c;
  end

  assign cfg_o   = cfg_q;
  assign vbase_o = vbase_q;

  // R12: read data only moves on a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/pic_src_cond.sv
module pic_src_cond #(
  parameter bit PROG     = 1'b0,  // sensing and polarity taken from config
  parameter bit FIX_EDGE = 1'b0,  // fixed sensing when not programmable
  parameter int LW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          edge_md_i,
  input  logic          act_hi_i,
  input  logic          clr_i,
  output logic          pend_o
);
  logic en, use_edge, act, prev_q, pend_q, rise;

  assign en       = (lvl_i != '0);
  assign use_edge = PROG ? edge_md_i : FIX_EDGE;
  assign act      = PROG ? (raw_i ^ ~act_hi_i) : raw_i;
  assign rise     = act & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= act;
      if (!en)
        pend_q <= 1'b0;
      else if (use_edge)
        pend_q <= (pend_q & ~clr_i) | rise;
      else
        pend_q <= act;
    end
  end

  assign pend_o = pend_q;

  // R3: a disabled source holds no request
  p_off_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pend_o);
  // R5: a latched edge request survives until acknowledged
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_o && en && use_edge && !clr_i) |=> pend_o);
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NSRC = 28,
  parameter int IW   = 5,
  parameter int LW   = 3
) (
  input  logic [NSRC-1:0]         pend_i,
  input  logic [NSRC-1:0][LW-1:0] lvl_i,
  input  logic [LW-1:0]           ack_lvl_i,
  output logic [LW-1:0]           max_lvl_o,
  output logic                    hit_o,
  output logic [IW-1:0]           win_o
);
  always_comb begin
    max_lvl_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_i[i] && lvl_i[i] > max_lvl_o) max_lvl_o = lvl_i[i];
  end

  // scan downward so the lowest index at the level is kept last
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend_i[i] && ack_lvl_i != '0 && lvl_i[i] == ack_lvl_i) begin
        hit_o = 1'b1;
        win_o = IW'(i);
      end
  end
endmodule

// File: rtl/pic_irq_ctrl.sv
module pic_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NBP       = 7,
  parameter int NLOC      = 7,
  parameter int NERR      = 6,
  parameter int NSW       = 8,
  parameter int VW        = 8,
  parameter int VBASE_RST = 2,
  localparam int NSRC     = NBP + NLOC + NERR + NSW,
  localparam int AW       = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBP-1:0]    bp_irq_i,
  input  logic [NLOC-1:0]   loc_irq_i,
  input  logic [NERR-1:0]   err_evt_i,
  input  logic [NSW-1:0]    sw_evt_i,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic [LVLW-1:0]   ipl_o,
  input  logic              iack_req_i,
  input  logic [LVLW-1:0]   iack_lvl_i,
  output logic              iack_ack_o,
  output logic              iack_hit_o,
  output logic              iack_own_o,
  output logic [VW-1:0]     iack_vec_o
);
  localparam int IW     = $clog2(NSRC);
  localparam int VBW    = VW - IW;
  localparam int LOC_LO = NBP;
  localparam int ERR_LO = NBP + NLOC;

  logic [NSRC-1:0]           raw, pend, clr;
  logic [NSRC-1:0][LVLW-1:0] lvl_v;
  src_cfg_t [NSRC-1:0]       cfg;
  logic [VBW-1:0]            vbase;
  logic [LVLW-1:0]           max_lvl;
  logic                      hit, own_c;
  logic [IW-1:0]             win;

  assign raw = {sw_evt_i, err_evt_i, loc_irq_i, bp_irq_i};

  pic_cfg_regs #(.NSRC(NSRC), .AW(AW), .VBW(VBW), .VBASE_RST(VBASE_RST), .DW(8)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .re_i(cfg_re_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .cfg_o(cfg), .vbase_o(vbase), .rdata_o(cfg_rdata_o));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam bit IS_LOC  = (g >= LOC_LO) && (g < ERR_LO);
    localparam bit IS_EDGE = (g >= ERR_LO);
    assign lvl_v[g] = cfg[g].lvl;
    assign clr[g]   = iack_req_i && hit && (win == IW'(g));
    pic_src_cond #(.PROG(IS_LOC), .FIX_EDGE(IS_EDGE), .LW(LVLW)) u_cond (
      .clk(clk), .rst(rst), .raw_i(raw[g]), .lvl_i(cfg[g].lvl),
      .edge_md_i(cfg[g].edge_md), .act_hi_i(cfg[g].act_hi),
      .clr_i(clr[g]), .pend_o(pend[g]));
  end

  pic_prio_enc #(.NSRC(NSRC), .IW(IW), .LW(LVLW)) u_enc (
    .pend_i(pend), .lvl_i(lvl_v), .ack_lvl_i(iack_lvl_i),
    .max_lvl_o(max_lvl), .hit_o(hit), .win_o(win));

  // only local lines may hand the vector to the device
  always_comb begin
    own_c = 1'b1;
    for (int i = 0; i < NSRC; i++)
      if (win == IW'(i))
        own_c = cfg[i].vsup || !((i >= LOC_LO) && (i < ERR_LO));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_o      <= '0;
      iack_ack_o <= 1'b0;
      iack_hit_o <= 1'b0;
      iack_own_o <= 1'b0;
      iack_vec_o <= '0;
    end else begin
      ipl_o      <= max_lvl;
      iack_ack_o <= iack_req_i;
      iack_hit_o <= iack_req_i && hit;
      iack_own_o <= iack_req_i && hit && own_c;
      iack_vec_o <= (iack_req_i && hit && own_c) ? {vbase, win} : '0;
    end
  end

  // R7: a response only follows a request
  p_ack_after_req_r7: assert property (@(posedge clk) disable iff (rst)
    iack_ack_o |-> $past(iack_req_i));
  // R11: a miss returns nothing
  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (iack_ack_o && !iack_hit_o) |-> (iack_vec_o == '0 && !iack_own_o));
  // R11: level 0 can never be a hit
  p_hit_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
    iack_hit_o |-> ($past(iack_lvl_i) != '0));
  // R2: nothing pending gives a zero code next cycle
  p_idle_code_r2: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (ipl_o == '0));
endmodule

// File: tb/pic_irq_ctrl_tb.sv
module pic_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bp = '0, loc = '0;
  logic [5:0] err = '0;
  logic [7:0] sw = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ipl;
  logic       req = 1'b0;
  logic [2:0] alvl = '0;
  logic       ack, hit, own;
  logic [7:0] vec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  pic_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bp_irq_i(bp), .loc_irq_i(loc), .err_evt_i(err), .sw_evt_i(sw),
    .cfg_we_i(we), .cfg_re_i(re), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .ipl_o(ipl), .iack_req_i(req), .iack_lvl_i(alvl), .iack_ack_o(ack), .iack_hit_o(hit),
    .iack_own_o(own), .iack_vec_o(vec));

  // {bp[6:0], loc[6:0], expected ipl}
  localparam logic [16:0] VECS [8] = '{
    {7'b0000000, 7'b0000000, 3'd0},
    {7'b0000001, 7'b0000000, 3'd1},
    {7'b0000101, 7'b0000000, 3'd3},
    {7'b0000000, 7'b0000001, 3'd3},
    {7'b0000010, 7'b0000010, 3'd5},
    {7'b1000000, 7'b0000000, 3'd7},
    {7'b0000000, 7'b1111000, 3'd0},
    {7'b0001000, 7'b0000100, 3'd5}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ack(input logic [2:0] l);
    @(negedge clk); req = 1'b1; alvl = l;
    @(negedge clk); req = 1'b0; alvl = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ipl", {5'd0, ipl}, 8'h00);
    rd(5'd7, d);  check("R1/R12 cfg readback", d, 8'h30);
    rd(5'd28, d); check("R1 vector base", d, 8'h02);

    // R3: all sources disabled
    bp = '1; loc = '1; err = '1; sw = '1;
    settle(); check("R3 disabled ipl", {5'd0, ipl}, 8'h00);
    bp = '0; loc = '0; err = '0; sw = '0;
    settle(); check("R3 no stale latch", {5'd0, ipl}, 8'h00);

    for (int i = 0; i < 7; i++) wr(5'(i), 8'(i + 1) | 8'h30);
    wr(5'd7, 8'h33); wr(5'd8, 8'h35); wr(5'd9, 8'h35);

    // R2/R4: table walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); bp = VECS[v][16:10]; loc = VECS[v][9:3];
      settle();
      check($sformatf("R2/R4 vector %0d", v), {5'd0, ipl}, {5'd0, VECS[v][2:0]});
    end
    bp = '0; loc = '0; settle();

    // R7 tie-break, R8 level request persists
    loc = 7'b0000110; settle();
    check("R2 tie ipl", {5'd0, ipl}, 8'h05);
    do_ack(3'd5);
    check("R7 ack", {7'd0, ack}, 8'h01);
    check("R7 hit", {7'd0, hit}, 8'h01);
    check("R7 lowest index vec", vec, 8'h48);
    check("R9 own local vsup", {7'd0, own}, 8'h01);
    @(negedge clk); check("R7 ack one cycle", {7'd0, ack}, 8'h00);
    settle(); check("R8 level stays", {5'd0, ipl}, 8'h05);
    do_ack(3'd5); check("R8 again vec", vec, 8'h48);
    loc = 7'b0000100; settle();
    do_ack(3'd5); check("R7 next index vec", vec, 8'h49);
    do_ack(3'd6);
    check("R11 miss hit", {7'd0, hit}, 8'h00);
    check("R11 miss vec", vec, 8'h00);
    check("R11 miss own", {7'd0, own}, 8'h00);
    do_ack(3'd0); check("R11 level0 hit", {7'd0, hit}, 8'h00);
    loc = '0; settle(); check("R4 released", {5'd0, ipl}, 8'h00);

    // R5 edge latch, R9 device-supplied vector
    wr(5'd10, 8'h1E);
    @(negedge clk); loc[3] = 1'b1; @(negedge clk); loc[3] = 1'b0;
    settle(); check("R5 latched", {5'd0, ipl}, 8'h06);
    do_ack(3'd6);
    check("R9 hit", {7'd0, hit}, 8'h01);
    check("R9 own clear", {7'd0, own}, 8'h00);
    check("R9 vec zero", vec, 8'h00);
    settle(); check("R8 edge cleared", {5'd0, ipl}, 8'h00);

    // R6 active-low
    wr(5'd11, 8'h24); settle();
    check("R6 low active", {5'd0, ipl}, 8'h04);
    loc[4] = 1'b1; settle();
    check("R6 high idle", {5'd0, ipl}, 8'h00);
    wr(5'd11, 8'h20); loc = '0; settle();

    // R10 fixed-sense groups
    wr(5'd14, 8'h02);
    @(negedge clk); err[0] = 1'b1; @(negedge clk); err[0] = 1'b0;
    settle(); check("R10 err latched", {5'd0, ipl}, 8'h02);
    do_ack(3'd2); check("R10 err vec", vec, 8'h4E);
    settle(); check("R8 err cleared", {5'd0, ipl}, 8'h00);
    wr(5'd20, 8'h07);
    @(negedge clk); sw[0] = 1'b1; @(negedge clk); sw[0] = 1'b0;
    settle(); check("R10 sw latched", {5'd0, ipl}, 8'h07);
    do_ack(3'd7);
    check("R10 sw own", {7'd0, own}, 8'h01);
    check("R10 sw vec", vec, 8'h54);
    settle();
    wr(5'd0, 8'h09);
    bp[0] = 1'b1; settle(); check("R10 bp active-high", {5'd0, ipl}, 8'h01);
    bp[0] = 1'b0; settle(); check("R10 bp level", {5'd0, ipl}, 8'h00);

    // R12 vector base and readback
    wr(5'd28, 8'h05);
    @(negedge clk); err[0] = 1'b1; @(negedge clk); err[0] = 1'b0;
    settle(); do_ack(3'd2); check("R12 new base vec", vec, 8'hAE);
    rd(5'd28, d); check("R12 base readback", d, 8'h05);
    rd(5'd10, d); check("R12 cfg readback", d, 8'h1E);
    @(negedge clk); check("R12 rdata held", rdata, 8'h1E);

    // R3 disable discards a latch
    @(negedge clk); err[0] = 1'b1; @(negedge clk); err[0] = 1'b0;
    settle(); check("R3 pre-disable", {5'd0, ipl}, 8'h02);
    wr(5'd14, 8'h00); settle(); check("R3 disabled", {5'd0, ipl}, 8'h00);
    wr(5'd14, 8'h02); settle(); check("R3 latch gone", {5'd0, ipl}, 8'h00);

    finish_run();
  end
endmodule